// File: doc/BRIEF.md
# Four-Phase Handshake Fork Combiner

This block connects one producer to several consumers. All of them use a four-phase request/acknowledge handshake: request rises, acknowledge rises, request falls, acknowledge falls. The block sends the producer's request to every consumer and returns one merged acknowledge to the producer. The data word goes straight from the producer to all consumers, with no register in between. The producer must hold the word steady while its request is high.

The merged acknowledge works like a Muller C-element. It goes high only when every consumer acknowledge is high. It goes low only when every consumer acknowledge is low. While the consumers disagree, it keeps its last value. A fast consumer therefore cannot let the producer move on before the slow one has caught up, in either half of the handshake. The block samples on a single clock. A synchronous active-high reset clears it, and all of its control outputs are registered.

Top module: `hs_fork_join`

## Requirements
- R1: During reset and in the first cycle after it, `up_ack` is 0 and every bit of `dn_req` is 0.
- R2: Each bit of `dn_req` equals the value `up_req` had at the previous rising clock edge, which is one cycle of latency.
- R3: `dn_data` equals `up_data` in the same cycle, with no register between them.
- R4: When every bit of `dn_ack` is 1 at a rising edge, `up_ack` is 1 after that edge.
- R5: When every bit of `dn_ack` is 0 at a rising edge, `up_ack` is 0 after that edge.
- R6: When the bits of `dn_ack` disagree at a rising edge, `up_ack` keeps its previous value. This holds both while it is low and while it is high.
- R7: A single consumer that holds `dn_ack` high for many cycles, while another stays low, never causes `up_ack` to rise.
- R8: With consumers that answer after random delays, each word is delivered to each consumer exactly once and in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req | input | 1 | Request from the producer |
| up_ack | output | 1 | Merged acknowledge to the producer |
| up_data | input | DATA_W | Data word from the producer |
| dn_req | output | NUM_SINKS | Request to each consumer, bit i for consumer i |
| dn_ack | input | NUM_SINKS | Acknowledge from each consumer, bit i for consumer i |
| dn_data | output | DATA_W | Data word to all consumers |

## Verification
The assertions check the merge rule on every clock edge. These are the set, clear and hold cases of R4 to R6, the one-cycle request forwarding of R2, and the post-reset low state. Only the bench scenarios can show the end-to-end properties. These are the long one-sided acknowledge of R7, and exactly-once in-order delivery to each randomly delayed consumer over many full handshakes (R8). The same scenarios also show that the comparison of `dn_data` against `up_data` (R3) holds throughout.

// File: rtl/hs_fork_pkg.sv
package hs_fork_pkg;
  typedef enum logic {
    JOIN_LOW  = 1'b0,
    JOIN_HIGH = 1'b1
  } join_state_t;
endpackage

// File: rtl/hs_req_fanout.sv
module hs_req_fanout #(
  parameter int NUM_SINKS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_in,
  output logic [NUM_SINKS-1:0] req_out
);
  genvar gi;
  generate
    for (gi = 0; gi < NUM_SINKS; gi++) begin : g_sink
      always_ff @(posedge clk) begin
        if (rst) req_out[gi] <= 1'b0;
        else     req_out[gi] <= req_in;
      end
    end
  endgenerate

  // R2
  req_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> req_out == {NUM_SINKS{$past(req_in)}});

  // R1
  req_reset_chk: assert property (@(posedge clk)
    rst |=> req_out == '0);
endmodule

// File: rtl/hs_ack_join.sv
module hs_ack_join
  import hs_fork_pkg::*;
#(
  parameter int NUM_SINKS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SINKS-1:0] ack_in,
  output logic                 ack_out
);
  join_state_t state_q, state_d;
  logic all_hi, all_lo;

  assign all_hi = &ack_in;
  assign all_lo = ~|ack_in;

  always_comb begin
    state_d = state_q;
    case (state_q)
      JOIN_LOW:  if (all_hi) state_d = JOIN_HIGH;
      JOIN_HIGH: if (all_lo) state_d = JOIN_LOW;
      default:   state_d = JOIN_LOW;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= JOIN_LOW;
    else     state_q <= state_d;
  end

  assign ack_out = (state_q == JOIN_HIGH);

  // R4
  join_set_chk: assert property (@(posedge clk) disable iff (rst)
    (&ack_in) |=> ack_out);

  // R5
  join_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (~|ack_in) |=> !ack_out);

  // R6
  join_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(&ack_in) && (|ack_in)) |=> $stable(ack_out));

  // R1
  join_reset_chk: assert property (@(posedge clk)
    rst |=> !ack_out);
endmodule

// File: rtl/hs_fork_join.sv
module hs_fork_join #(
  parameter int DATA_W    = 16,
  parameter int NUM_SINKS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 up_req,
  output logic                 up_ack,
  input  logic [DATA_W-1:0]    up_data,
  output logic [NUM_SINKS-1:0] dn_req,
  input  logic [NUM_SINKS-1:0] dn_ack,
  output logic [DATA_W-1:0]    dn_data
);
  hs_req_fanout #(.NUM_SINKS(NUM_SINKS)) u_fanout (
    .clk     (clk),
    .rst     (rst),
    .req_in  (up_req),
    .req_out (dn_req)
  );

  hs_ack_join #(.NUM_SINKS(NUM_SINKS)) u_join (
    .clk     (clk),
    .rst     (rst),
    .ack_in  (dn_ack),
    .ack_out (up_ack)
  );

  // R3: data is not registered; the producer holds it while requesting
  assign dn_data = up_data;
endmodule

// File: tb/hs_fork_join_test.sv
`timescale 1ns/1ps
module hs_fork_join_test;
  localparam int DW = 16;
  localparam int NS = 2;
  localparam int N_XFER = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up_req = 1'b0;
  logic up_ack;
  logic [DW-1:0] up_data = '0;
  logic [NS-1:0] dn_req;
  logic [NS-1:0] ack_q = '0;
  logic [DW-1:0] dn_data;

  int n_checks = 0;
  int n_fail = 0;
  bit stop = 1'b0;
  bit mon_on = 1'b0;
  logic [DW-1:0] q0[$];
  logic [DW-1:0] q1[$];
  int got0 = 0, got1 = 0;

  always #5 clk = ~clk;

  hs_fork_join #(.DATA_W(DW), .NUM_SINKS(NS)) uut (
    .clk(clk), .rst(rst), .up_req(up_req), .up_ack(up_ack),
    .up_data(up_data), .dn_req(dn_req), .dn_ack(ack_q), .dn_data(dn_data)
  );

  task automatic check(input bit ok, input string rq,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  // Monitor: merged acknowledge may move only as the acks seen at the edge allow
  logic [NS-1:0] ack_at_edge = '0;
  logic prev_up_ack = 1'b0;
  always @(posedge clk) ack_at_edge <= ack_q;
  always @(negedge clk) begin
    if (mon_on) begin
      if (up_ack && !prev_up_ack)
        check(ack_at_edge == '1, "R4/R7 rise", ack_at_edge, '1);
      if (!up_ack && prev_up_ack)
        check(ack_at_edge == '0, "R5/R6 fall", ack_at_edge, 0);
      check(dn_data == up_data, "R3", dn_data, up_data);
    end
    prev_up_ack <= up_ack;
  end

  task automatic producer();
    for (int k = 0; k < N_XFER; k++) begin
      @(negedge clk);
      while (up_ack) @(negedge clk);
      up_data = DW'($urandom);
      q0.push_back(up_data);
      q1.push_back(up_data);
      up_req = 1'b1;
      do @(negedge clk); while (!up_ack);
      up_req = 1'b0;
      do @(negedge clk); while (up_ack);
    end
    stop = 1'b1;
  endtask

  task automatic consumer(input int idx);
    logic [DW-1:0] exp;
    while (!stop) begin
      @(negedge clk);
      while (!dn_req[idx] && !stop) @(negedge clk);
      if (stop) break;
      repeat ($urandom_range(0, 4)) @(negedge clk);
      if (idx == 0) begin
        exp = (q0.size() > 0) ? q0.pop_front() : '0;
        got0++;
      end else begin
        exp = (q1.size() > 0) ? q1.pop_front() : '0;
        got1++;
      end
      check(dn_data == exp, "R8 data", dn_data, exp);
      ack_q[idx] = 1'b1;
      do @(negedge clk); while (dn_req[idx]);
      repeat ($urandom_range(0, 4)) @(negedge clk);
      ack_q[idx] = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(up_ack == 1'b0, "R1 ack", up_ack, 0);
    check(dn_req == '0, "R1 req", dn_req, 0);
    rst = 1'b0;
    @(negedge clk);
    check(up_ack == 1'b0 && dn_req == '0, "R1 after", {dn_req, up_ack}, 0);
    mon_on = 1'b1;

    up_data = 16'hA55A;
    up_req = 1'b1;
    #1 check(dn_data == 16'hA55A, "R3 pass", dn_data, 16'hA55A);
    @(negedge clk);
    check(dn_req == 2'b11, "R2 rise", dn_req, 2'b11);
    ack_q[0] = 1'b1;
    repeat (5) @(negedge clk);
    check(up_ack == 1'b0, "R7 one sided", up_ack, 0);
    ack_q[1] = 1'b1;
    @(negedge clk);
    check(up_ack == 1'b1, "R4 set", up_ack, 1);
    up_req = 1'b0;
    @(negedge clk);
    check(dn_req == 2'b00, "R2 fall", dn_req, 0);
    ack_q[1] = 1'b0;
    repeat (3) @(negedge clk);
    check(up_ack == 1'b1, "R6 hold high", up_ack, 1);
    ack_q[0] = 1'b0;
    @(negedge clk);
    check(up_ack == 1'b0, "R5 clear", up_ack, 0);
    ack_q[1] = 1'b1;
    repeat (2) @(negedge clk);
    check(up_ack == 1'b0, "R6 hold low", up_ack, 0);
    ack_q[1] = 1'b0;
    repeat (2) @(negedge clk);

    fork
      producer();
      consumer(0);
      consumer(1);
    join
    repeat (3) @(negedge clk);
    check(got0 == N_XFER, "R8 count0", got0, N_XFER);
    check(got1 == N_XFER, "R8 count1", got1, N_XFER);
    check(q0.size() == 0 && q1.size() == 0, "R8 leftover",
          q0.size() + q1.size(), 0);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end
endmodule